// File: doc/BRIEF.md
# Register stack frame manager

This unit keeps track of procedure register frames for the stacked part of a register file, virtual numbers 32 to 127. The registers behind that range live in a circular physical buffer. A moving frame base decides which physical slot stands for virtual register 32. Software gives each frame a local count and an output count with an allocate command. A call moves the base past the caller's locals, so the caller's outputs become the callee's first registers without any copying. A return puts the caller's frame back, using a small stack of saved counts.

Slots that belong to older frames stay in the buffer as long as there is room for them. If an allocate or a return needs more slots than the buffer has free, the unit first asks memory to save the oldest live slots. If a return finds that part of the caller's frame was saved earlier, it asks memory to load those slots back. Both kinds of request go out on a valid/ready port that carries a physical slot number and a backing-store address. The data path and the memory are not part of this unit.

A registered lookup turns any virtual register number into its physical slot. It also reports whether that number falls inside the current frame.

Top module: `rsf_top`

## Requirements
- R1: After a synchronous active-high reset: both frame counts are 0, `busy` is 0, `cmd_ready` is 1, `err` is 0 and `mem_valid` is 0.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge. Command codes on `cmd_op`: 1 = allocate, 2 = call, 3 = return, 0 = no operation. An accepted allocate sets the frame's local and output counts to `cmd_loc` and `cmd_out`. If `cmd_loc + cmd_out` exceeds FMAX (96), the allocate is rejected: `err` is high for one cycle after the accepting edge and both counts stay as they were.
- R3: `map_hit` and `map_slot` are registered. They respond to `map_vreg` one cycle later. `map_hit` is 1 only when `32 <= map_vreg < 32 + local + output`. When it is 1, `map_slot = (base + map_vreg - 32) mod NPHYS`. The base is 0 after reset.
- R4: An accepted call saves the caller's counts and adds the caller's local count to the base. The callee starts with a local count of 0 and an output count equal to the caller's output count. So caller virtual register 32+local maps to the same slot as callee register 32.
- R5: An accepted return restores the saved local and output counts and subtracts the saved local count from the base.
- R6: The saved stack holds DEPTH (8) frames. A call made with 8 frames saved, or a return made with none saved, raises `err` and leaves the frame unchanged.
- R7: When the live slots (older frames' slots still held in the buffer, plus the current frame) would exceed NPHYS (128), the unit spills the excess. Spill requests have `mem_write` = 1 and go oldest slot first. The first address is all ones, and each later address is one lower.
- R8: When a return needs caller slots that were spilled earlier, the unit fills them back. Fill requests have `mem_write` = 0 and go in the reverse of spill order: youngest slot first, at ascending addresses, each at the address where that slot was spilled.
- R9: While any spill or fill is outstanding, `busy` is 1 and `cmd_ready` is 0. A command held on `cmd_valid` during that time is not taken until the requests are done.
- R10: While `mem_valid` is high and `mem_ready` is low, the slot, address and direction of the request stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 none, 1 allocate, 2 call, 3 return |
| cmd_loc | input | CW | Local count for allocate |
| cmd_out | input | CW | Output count for allocate |
| cmd_ready | output | 1 | Command can be taken this cycle |
| err | output | 1 | One-cycle flag for a rejected command |
| busy | output | 1 | Spill or fill outstanding |
| frame_loc | output | CW | Current local count |
| frame_out | output | CW | Current output count |
| map_vreg | input | 7 | Virtual register number to translate |
| map_hit | output | 1 | Number lies inside the current frame |
| map_slot | output | SW | Physical slot for that number |
| mem_valid | output | 1 | Spill/fill request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 spill, 0 fill |
| mem_slot | output | SW | Physical slot to save or restore |
| mem_addr | output | AW | Backing-store address |

## Verification
Allocation, calling and returning are first tried with small frames that never fill the buffer. Lookups taken just below, at the start of and just past the frame edge show whether the base and the size are both applied correctly. A call chain eight frames deep, followed by one more call, separates correct stack-full handling from a silent overwrite. Two near-maximum frames force 28 spills, and the matching returns force 28 fills. The recorded slot and address sequences show whether oldest-first, descending order and its exact reverse are kept. A command held during the spill shows that stalling works. A memory side that often drops ready tests the hold rule.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int VREG_W        = 7;
  localparam int STACKED_FIRST = 32;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_ALLOC = 2'd1,
    OP_CALL  = 2'd2,
    OP_RET   = 2'd3
  } rsf_op_e;
endpackage

// File: rtl/rsf_frame_stack.sv
// LIFO of saved caller counts; storage has no reset so it can map to RAM.
module rsf_frame_stack #(
  parameter int DEPTH = 8,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] push_loc,
  input  logic [CW-1:0] push_out,
  output logic [CW-1:0] top_loc,
  output logic [CW-1:0] top_out,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] loc_mem [DEPTH];
  logic [CW-1:0] out_mem [DEPTH];
  logic [PW-1:0] sp;
  logic [IW-1:0] wr_idx, rd_idx;

  assign wr_idx  = IW'(sp);
  assign rd_idx  = IW'(sp - PW'(1));
  assign full    = (sp == PW'(DEPTH));
  assign empty   = (sp == '0);
  assign top_loc = loc_mem[rd_idx];
  assign top_out = out_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      loc_mem[wr_idx] <= push_loc;
      out_mem[wr_idx] <= push_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + PW'(1);
    else if (pop)  sp <= sp - PW'(1);
  end
endmodule

// File: rtl/rsf_mapper.sv
// Registered virtual-to-physical translation for the stacked range.
module rsf_mapper
  import rsf_pkg::*;
#(
  parameter int NPHYS = 128,
  parameter int CW    = 7,
  localparam int SW   = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VREG_W-1:0] vreg,
  input  logic [SW-1:0]     base,
  input  logic [CW:0]       size,
  output logic              hit,
  output logic [SW-1:0]     slot
);
  logic [VREG_W-1:0] off;
  logic              in_frame;

  always_comb begin
    off      = vreg - VREG_W'(STACKED_FIRST);
    in_frame = (int'(vreg) >= STACKED_FIRST) && (int'(off) < int'(size));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      slot <= '0;
    end else begin
      hit  <= in_frame;
      slot <= base + SW'(off);
    end
  end
endmodule

// File: rtl/rsf_mem_seq.sv
// Issues spill or fill requests one slot at a time and owns the backing pointer.
module rsf_mem_seq #(
  parameter int NPHYS = 128,
  parameter int AW    = 16,
  localparam int SW   = $clog2(NPHYS),
  localparam int NW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_fill,
  input  logic [NW-1:0] start_cnt,
  input  logic [SW-1:0] base,
  input  logic [NW-1:0] ndirty,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [SW-1:0] mem_slot,
  output logic [AW-1:0] mem_addr,
  output logic          xfer
);
  logic [NW-1:0] cnt;
  logic          fill_mode;
  logic [AW-1:0] bsp;

  assign mem_valid = (cnt != '0);
  assign mem_write = ~fill_mode;
  assign xfer      = mem_valid & mem_ready;
  assign mem_slot  = fill_mode ? base + SW'(cnt - NW'(1)) : base - SW'(ndirty);
  assign mem_addr  = fill_mode ? bsp + AW'(1) : bsp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      fill_mode <= 1'b0;
      bsp       <= '1;
    end else if (start) begin
      cnt       <= start_cnt;
      fill_mode <= start_fill;
    end else if (xfer) begin
      cnt <= cnt - NW'(1);
      bsp <= fill_mode ? bsp + AW'(1) : bsp - AW'(1);
    end
  end
endmodule

// File: rtl/rsf_top.sv
// Frame control: base, counts, count of older live slots, command decode.
module rsf_top
  import rsf_pkg::*;
#(
  parameter int NPHYS = 128,
  parameter int FMAX  = 96,
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int CW   = $clog2(FMAX + 1),
  localparam int SW   = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CW-1:0]     cmd_loc,
  input  logic [CW-1:0]     cmd_out,
  output logic              cmd_ready,
  output logic              err,
  output logic              busy,
  output logic [CW-1:0]     frame_loc,
  output logic [CW-1:0]     frame_out,
  input  logic [VREG_W-1:0] map_vreg,
  output logic              map_hit,
  output logic [SW-1:0]     map_slot,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [SW-1:0]     mem_slot,
  output logic [AW-1:0]     mem_addr
);
  localparam int NW = SW + 1;
  localparam int XW = SW + 3;

  logic [SW-1:0] base, base_n;
  logic [NW-1:0] nd, nd_n;
  logic [CW-1:0] loc_n, out_n;
  logic          accept, reject;
  logic          push, pop, stk_full, stk_empty;
  logic [CW-1:0] stk_loc, stk_out;
  logic          seq_start, seq_fill, seq_xfer;
  logic [NW-1:0] seq_cnt;
  logic [XW-1:0] sum_x, foot_x, ndk_x;
  rsf_op_e       op;

  assign op        = rsf_op_e'(cmd_op);
  assign busy      = mem_valid;
  assign cmd_ready = ~mem_valid;
  assign accept    = cmd_valid & ~mem_valid;
  assign push      = accept & (op == OP_CALL) & ~stk_full;
  assign pop       = accept & (op == OP_RET) & ~stk_empty;

  always_comb begin
    base_n    = base;
    nd_n      = nd;
    loc_n     = frame_loc;
    out_n     = frame_out;
    reject    = 1'b0;
    seq_start = 1'b0;
    seq_fill  = 1'b0;
    seq_cnt   = '0;
    sum_x     = XW'(cmd_loc) + XW'(cmd_out);
    foot_x    = '0;
    ndk_x     = '0;
    unique case (op)
      OP_ALLOC: begin
        if (sum_x > XW'(FMAX)) begin
          reject = 1'b1;
        end else begin
          loc_n  = cmd_loc;
          out_n  = cmd_out;
          foot_x = XW'(nd) + sum_x;
          if (foot_x > XW'(NPHYS)) begin
            seq_start = 1'b1;
            seq_cnt   = NW'(foot_x - XW'(NPHYS));
          end
        end
      end
      OP_CALL: begin
        if (stk_full) begin
          reject = 1'b1;
        end else begin
          base_n = base + SW'(frame_loc);
          nd_n   = nd + NW'(frame_loc);
          loc_n  = '0;
          out_n  = frame_out;
        end
      end
      OP_RET: begin
        if (stk_empty) begin
          reject = 1'b1;
        end else begin
          base_n = base - SW'(stk_loc);
          loc_n  = stk_loc;
          out_n  = stk_out;
          if (XW'(nd) >= XW'(stk_loc)) begin
            ndk_x  = XW'(nd) - XW'(stk_loc);
            nd_n   = NW'(ndk_x);
            foot_x = ndk_x + XW'(stk_loc) + XW'(stk_out);
            if (foot_x > XW'(NPHYS)) begin
              seq_start = 1'b1;
              seq_cnt   = NW'(foot_x - XW'(NPHYS));
            end
          end else begin
            nd_n      = '0;
            seq_start = 1'b1;
            seq_fill  = 1'b1;
            seq_cnt   = NW'(XW'(stk_loc) - XW'(nd));
          end
        end
      end
      default: ;
    endcase
    seq_start = seq_start & accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      nd        <= '0;
      frame_loc <= '0;
      frame_out <= '0;
      err       <= 1'b0;
    end else begin
      err <= accept & reject;
      if (accept && !reject) begin
        base      <= base_n;
        nd        <= nd_n;
        frame_loc <= loc_n;
        frame_out <= out_n;
      end else if (seq_xfer && mem_write) begin
        nd <= nd - NW'(1);
      end
    end
  end

  rsf_frame_stack #(.DEPTH(DEPTH), .CW(CW)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_loc(frame_loc), .push_out(frame_out),
    .top_loc(stk_loc), .top_out(stk_out),
    .full(stk_full), .empty(stk_empty)
  );

  rsf_mapper #(.NPHYS(NPHYS), .CW(CW)) u_map (
    .clk(clk), .rst(rst), .vreg(map_vreg), .base(base),
    .size((CW+1)'(frame_loc) + (CW+1)'(frame_out)),
    .hit(map_hit), .slot(map_slot)
  );

  rsf_mem_seq #(.NPHYS(NPHYS), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(seq_start), .start_fill(seq_fill),
    .start_cnt(seq_cnt), .base(base), .ndirty(nd), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_slot(mem_slot),
    .mem_addr(mem_addr), .xfer(seq_xfer)
  );
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter int FMAX = 96,
  parameter int CW   = 7,
  parameter int SW   = 7,
  parameter int AW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [CW-1:0] cmd_loc,
  input logic [CW-1:0] cmd_out,
  input logic          cmd_ready,
  input logic          err,
  input logic          busy,
  input logic [CW-1:0] frame_loc,
  input logic [CW-1:0] frame_out,
  input logic [6:0]    map_vreg,
  input logic          map_hit,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [SW-1:0] mem_slot,
  input logic [AW-1:0] mem_addr
);
  // R2: oversize allocate flags err and keeps the frame
  p_alloc_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd1 &&
     (int'(cmd_loc) + int'(cmd_out) > FMAX))
    |=> (err && frame_loc == $past(frame_loc) && frame_out == $past(frame_out)));

  // R2: frame never larger than the limit
  p_size_limit_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(frame_loc) + int'(frame_out) <= FMAX));

  // R3: numbers below the stacked range never hit
  p_low_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (map_vreg < 7'd32) |=> !map_hit);

  // R4: callee starts with no locals and the caller's outputs
  p_call_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd2)
    |=> (err || (frame_loc == '0 && frame_out == $past(frame_out))));

  // R9: a command offered while busy is not taken
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(frame_loc) && $stable(frame_out) && !err));

  // R10: request held while memory is not ready
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready)
    |=> (mem_valid && $stable(mem_slot) && $stable(mem_addr) && $stable(mem_write)));
endmodule

bind rsf_top rsf_checker #(.FMAX(FMAX), .CW(CW), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_loc(cmd_loc), .cmd_out(cmd_out), .cmd_ready(cmd_ready), .err(err),
  .busy(busy), .frame_loc(frame_loc), .frame_out(frame_out),
  .map_vreg(map_vreg), .map_hit(map_hit), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_slot(mem_slot),
  .mem_addr(mem_addr)
);

// File: tb/rsf_top_test.sv
`timescale 1ns/1ps
module rsf_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_loc = '0, cmd_out = '0;
  logic       cmd_ready, err, busy, map_hit, mem_valid, mem_write;
  logic [6:0] frame_loc, frame_out, map_slot, mem_slot;
  logic [6:0] map_vreg = '0;
  logic       mem_ready = 1'b0;
  logic [15:0] mem_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsf_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_loc(cmd_loc), .cmd_out(cmd_out), .cmd_ready(cmd_ready), .err(err),
    .busy(busy), .frame_loc(frame_loc), .frame_out(frame_out),
    .map_vreg(map_vreg), .map_hit(map_hit), .map_slot(map_slot),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_slot(mem_slot), .mem_addr(mem_addr)
  );

  // memory side: records every transfer, ready drops one cycle in three
  logic [6:0]  log_slot [64];
  logic [15:0] log_addr [64];
  logic        log_wr   [64];
  int log_n = 0;
  int tick  = 0;
  always @(negedge clk) begin
    if (mem_valid && mem_ready && log_n < 64) begin
      log_slot[log_n] = mem_slot;
      log_addr[log_n] = mem_addr;
      log_wr[log_n]   = mem_write;
      log_n++;
    end
    tick++;
    mem_ready = (tick % 3) != 0;
  end

  typedef struct packed {
    logic [1:0] op;
    logic [6:0] l, o, el, eo;
    logic       eerr;
    logic [6:0] v;
    logic       ehit;
    logic [6:0] es;
  } vec_t;

  localparam vec_t TBL [0:7] = '{
    '{2'd1, 7'd10, 7'd5,  7'd10, 7'd5,  1'b0, 7'd46, 1'b1, 7'd14},
    '{2'd1, 7'd90, 7'd7,  7'd10, 7'd5,  1'b1, 7'd47, 1'b0, 7'd0 },
    '{2'd2, 7'd0,  7'd0,  7'd0,  7'd5,  1'b0, 7'd32, 1'b1, 7'd10},
    '{2'd1, 7'd3,  7'd4,  7'd3,  7'd4,  1'b0, 7'd38, 1'b1, 7'd16},
    '{2'd2, 7'd0,  7'd0,  7'd0,  7'd4,  1'b0, 7'd32, 1'b1, 7'd13},
    '{2'd3, 7'd0,  7'd0,  7'd3,  7'd4,  1'b0, 7'd31, 1'b0, 7'd0 },
    '{2'd3, 7'd0,  7'd0,  7'd10, 7'd5,  1'b0, 7'd44, 1'b1, 7'd12},
    '{2'd3, 7'd0,  7'd0,  7'd10, 7'd5,  1'b1, 7'd47, 1'b0, 7'd0 }
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [6:0] l, input logic [6:0] o);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_loc = l; cmd_out = o; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_map(input logic [6:0] v);
    map_vreg = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 loc", frame_loc, 0);
    check("R1 out", frame_out, 0);
    check("R1 busy", busy, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 err", err, 0);
    check("R1 mem_valid", mem_valid, 0);

    // table: R2 allocate, R4 call, R5 return, R6 empty return, R3 lookups
    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = (TBL[i].op == 2'd1) ? "R2" : (TBL[i].op == 2'd2) ? "R4" :
            TBL[i].eerr ? "R6" : "R5";
      do_cmd(TBL[i].op, TBL[i].l, TBL[i].o);
      check({tag, " err"}, err, TBL[i].eerr);
      check({tag, " loc"}, frame_loc, TBL[i].el);
      check({tag, " out"}, frame_out, TBL[i].eo);
      do_map(TBL[i].v);
      check("R3 hit", map_hit, TBL[i].ehit);
      if (TBL[i].ehit) check("R3 slot", map_slot, TBL[i].es);
    end
    check("R7 no spill for small frames", log_n, 0);

    // R6 saved stack full after eight calls
    for (int k = 0; k < 8; k++) do_cmd(2'd2, 0, 0);
    check("R6 eight calls ok", err, 0);
    do_cmd(2'd2, 0, 0);
    check("R6 ninth call err", err, 1);
    check("R6 ninth call loc", frame_loc, 0);
    check("R6 ninth call out", frame_out, 5);
    for (int k = 0; k < 8; k++) do_cmd(2'd3, 0, 0);
    check("R5 unwound loc", frame_loc, 10);
    check("R5 unwound out", frame_out, 5);
    do_map(7'd32);
    check("R5 unwound base", map_slot, 0);

    // spill and fill
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    do_cmd(2'd1, 60, 36);
    do_cmd(2'd2, 0, 0);
    do_cmd(2'd1, 60, 36);
    check("R9 busy during spill", busy, 1);
    check("R9 ready low during spill", cmd_ready, 0);
    cmd_op = 2'd2; cmd_loc = 0; cmd_out = 0; cmd_valid = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 held call not taken", frame_loc, 60);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 call taken after spill loc", frame_loc, 0);
    check("R9 call taken after spill out", frame_out, 36);
    check("R7 spill count", log_n, 28);
    for (int j = 0; j < 28; j++) begin
      check("R7 spill slot", log_slot[j], j);
      check("R7 spill addr", log_addr[j], 16'hFFFF - j);
      check("R7 spill dir", log_wr[j], 1);
    end
    do_cmd(2'd3, 0, 0);
    check("R5 first return loc", frame_loc, 60);
    check("R8 no fill needed", busy, 0);
    do_map(7'd32);
    check("R5 first return base", map_slot, 60);
    do_cmd(2'd3, 0, 0);
    check("R9 busy during fill", busy, 1);
    wait_idle();
    check("R8 fill count", log_n, 56);
    for (int j = 0; j < 28; j++) begin
      check("R8 fill slot", log_slot[28 + j], 27 - j);
      check("R8 fill addr", log_addr[28 + j], 16'hFFE4 + j);
      check("R8 fill dir", log_wr[28 + j], 0);
    end
    check("R5 outer frame loc", frame_loc, 60);
    check("R5 outer frame out", frame_out, 36);
    do_map(7'd127);
    check("R3 top register hit", map_hit, 1);
    check("R3 top register slot", map_slot, 95);
    summary();
  end
endmodule